// File: doc/BRIEF.md
# Processor Supervisor with Watchdog and Undervoltage Override

This core supervises a processor from the digital side. It watches a strobe that software must keep toggling, a flag that says the supply has already been judged too low, and an active-low push-button reset line. It produces two active-low outputs: a warning that strobe activity has stopped, and a system reset.

The two outputs react to undervoltage in different ways. While the flag is high, both outputs are low. When the flag drops, the warning releases in that same cycle. The reset output stays low for a fixed number of further cycles. An enable input feeds the warning back into the reset path, so that a missed strobe deadline causes a stretched system reset rather than only a warning.

The supply comparison itself is done elsewhere. The undervoltage flag arrives synchronous to the clock. The strobe and the push-button line may be asynchronous, and both are synchronized inside the core.

Top module: `sup_wdog_top`

## Requirements
- R1: With `loop_en_i` low and no strobe edge, `wd_n_o` goes low on the TWP_CYCLES-th clock edge after counting starts.
- R2: A rising edge and a falling edge of `wd_strobe_i` both count as activity. The strobe passes a two-flop synchronizer, and the counter is cleared on the third rising clock edge after the strobe changes.
- R3: While `uv_flag_i` is high, `wd_n_o` is low, whether or not the timer has expired.
- R4: When `uv_flag_i` falls, `wd_n_o` returns high in the same cycle, with no clock edge needed.
- R5: While `uv_flag_i` is high, `rst_n_o` is low in the same cycle.
- R6: After its last cause goes away, `rst_n_o` stays low for TRST_CYCLES more clock edges and then goes high.
- R7: After a timeout, `wd_n_o` stays low until a strobe edge or a reset clears it. That event also restarts the count from zero.
- R8: While reset is asserted, the timer is held at zero. It starts counting from zero when `rst_n_o` goes high.
- R9: With `loop_en_i` high, a timeout asserts `rst_n_o` on the next clock edge and clears the warning one edge later. With `loop_en_i` low, a timeout leaves `rst_n_o` high.
- R10: A low on `mr_n_i` lasting fewer than DB_CYCLES clock edges after synchronization is ignored. A held low drives `rst_n_o` low DB_CYCLES+3 edges after it is applied.
- R11: While `por_n` is low, `rst_n_o` is low and `wd_n_o` is high. After `por_n` rises, `rst_n_o` goes high on the TRST_CYCLES-th clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| wd_strobe_i | input | 1 | Software activity strobe; any level change counts |
| uv_flag_i | input | 1 | Synchronous undervoltage flag, active high |
| mr_n_i | input | 1 | Manual reset request, active low, asynchronous |
| loop_en_i | input | 1 | Routes a watchdog timeout into the reset path |
| wd_n_o | output | 1 | Watchdog warning, active low |
| rst_n_o | output | 1 | System reset, active low, stretched |

## Verification
The assertions assume that `uv_flag_i` and `loop_en_i` change only between clock edges, because the reset and warning paths read them combinationally. The bench drives every input on the falling edge, so each value is stable well before the next rising edge. Strobe and push-button timing are measured against synchronizer latency, so the bench holds each level for whole clock periods. It also starts every scenario from a fresh power-on reset, so no scenario depends on counter state left by an earlier one.

// File: rtl/sup_pkg.sv
package sup_pkg;
    localparam int unsigned SYNC_STAGES = 2;

    typedef struct packed {
        logic undervolt;
        logic manual;
        logic watchdog;
    } rst_cause_t;
endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic por_n,
    input  logic d_i,
    output logic q_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_st_t;

    sync_st_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) s_q <= '{chain: {STAGES{RST_VAL}}};
        else        s_q <= s_d;
    end

    assign q_o = s_q.chain[STAGES-1];
endmodule

// File: rtl/sup_debounce.sv
module sup_debounce #(
    parameter int unsigned DB_CYCLES = 8
) (
    input  logic clk,
    input  logic por_n,
    input  logic raw_i,
    output logic stable_o
);
    localparam int unsigned CW = $clog2(DB_CYCLES + 1);

    typedef struct packed {
        logic          level;
        logic [CW-1:0] cnt;
    } db_st_t;

    db_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (raw_i != s_q.level) begin
            if (s_q.cnt == CW'(DB_CYCLES - 1)) begin
                s_d.level = raw_i;
                s_d.cnt   = '0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end else begin
            s_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) s_q <= '{level: 1'b1, cnt: '0};
        else        s_q <= s_d;
    end

    assign stable_o = s_q.level;

    // R10: counter never passes the debounce window
    p_db_bound_r10: assert property (@(posedge clk) disable iff (!por_n)
        s_q.cnt < CW'(DB_CYCLES));
    // R10: matching input never moves the filtered level
    p_db_hold_r10: assert property (@(posedge clk) disable iff (!por_n)
        (raw_i == stable_o) |=> $stable(stable_o));
endmodule

// File: rtl/sup_wd_timer.sv
module sup_wd_timer #(
    parameter int unsigned TWP_CYCLES = 64
) (
    input  logic clk,
    input  logic por_n,
    input  logic strobe_s_i,
    input  logic hold_i,
    output logic expired_o
);
    localparam int unsigned CW = $clog2(TWP_CYCLES + 1);

    typedef struct packed {
        logic          prev;
        logic [CW-1:0] count;
        logic          expired;
    } wd_st_t;

    wd_st_t s_d, s_q;
    logic   activity;

    always_comb begin
        s_d      = s_q;
        activity = strobe_s_i ^ s_q.prev;
        s_d.prev = strobe_s_i;
        if (hold_i || activity) begin
            s_d.count   = '0;
            s_d.expired = 1'b0;
        end else if (s_q.count == CW'(TWP_CYCLES - 1)) begin
            s_d.expired = 1'b1;
        end else begin
            s_d.count = s_q.count + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) s_q <= '{prev: 1'b0, count: '0, expired: 1'b0};
        else        s_q <= s_d;
    end

    assign expired_o = s_q.expired;

    // R1: count stays inside the timeout window
    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!por_n)
        s_q.count <= CW'(TWP_CYCLES - 1));
    // R1: expiry only follows a full count
    p_expire_at_limit_r1: assert property (@(posedge clk) disable iff (!por_n)
        $rose(s_q.expired) |-> ($past(s_q.count) == CW'(TWP_CYCLES - 1)));
    // R8: reset holds the timer clear
    p_hold_clear_r8: assert property (@(posedge clk) disable iff (!por_n)
        hold_i |=> (s_q.count == '0 && !s_q.expired));
    // R7: strobe activity reloads and releases
    p_edge_reload_r7: assert property (@(posedge clk) disable iff (!por_n)
        activity |=> (s_q.count == '0 && !s_q.expired));
endmodule

// File: rtl/sup_rst_stretch.sv
module sup_rst_stretch
    import sup_pkg::*;
#(
    parameter int unsigned TRST_CYCLES = 20
) (
    input  logic       clk,
    input  logic       por_n,
    input  rst_cause_t cause_i,
    output logic       active_o
);
    localparam int unsigned CW = $clog2(TRST_CYCLES + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } st_st_t;

    st_st_t s_d, s_q;
    logic   any_cause;

    always_comb begin
        s_d       = s_q;
        any_cause = |cause_i;
        if (any_cause)            s_d.cnt = CW'(TRST_CYCLES);
        else if (s_q.cnt != '0)   s_d.cnt = s_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) s_q <= '{cnt: CW'(TRST_CYCLES)};
        else        s_q <= s_d;
    end

    assign active_o = (s_q.cnt != '0);

    // R6: any cause reloads the full stretch
    p_load_r6: assert property (@(posedge clk) disable iff (!por_n)
        (|cause_i) |=> (s_q.cnt == CW'(TRST_CYCLES)));
    // R6: stretch drains one step per idle edge
    p_drain_r6: assert property (@(posedge clk) disable iff (!por_n)
        (!(|cause_i) && s_q.cnt != '0) |=> (s_q.cnt == $past(s_q.cnt) - 1'b1));
endmodule

// File: rtl/sup_wdog_top.sv
module sup_wdog_top
    import sup_pkg::*;
#(
    parameter int unsigned TWP_CYCLES  = 64,
    parameter int unsigned TRST_CYCLES = 20,
    parameter int unsigned DB_CYCLES   = 8
) (
    input  logic clk,
    input  logic por_n,
    input  logic wd_strobe_i,
    input  logic uv_flag_i,
    input  logic mr_n_i,
    input  logic loop_en_i,
    output logic wd_n_o,
    output logic rst_n_o
);
    logic       strobe_s;
    logic       mr_s;
    logic       mr_stable;
    logic       expired;
    logic       stretch_active;
    logic       rst_act;
    rst_cause_t cause;

    sup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_strobe_sync (
        .clk(clk), .por_n(por_n), .d_i(wd_strobe_i), .q_o(strobe_s));

    sup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_mr_sync (
        .clk(clk), .por_n(por_n), .d_i(mr_n_i), .q_o(mr_s));

    sup_debounce #(.DB_CYCLES(DB_CYCLES)) u_mr_db (
        .clk(clk), .por_n(por_n), .raw_i(mr_s), .stable_o(mr_stable));

    sup_wd_timer #(.TWP_CYCLES(TWP_CYCLES)) u_timer (
        .clk(clk), .por_n(por_n), .strobe_s_i(strobe_s),
        .hold_i(rst_act), .expired_o(expired));

    always_comb begin
        cause.undervolt = uv_flag_i;
        cause.manual    = ~mr_stable;
        cause.watchdog  = loop_en_i & expired;
    end

    sup_rst_stretch #(.TRST_CYCLES(TRST_CYCLES)) u_stretch (
        .clk(clk), .por_n(por_n), .cause_i(cause), .active_o(stretch_active));

    assign rst_act = uv_flag_i | stretch_active;
    assign rst_n_o = ~rst_act;
    assign wd_n_o  = ~(expired | uv_flag_i);

    // R5: undervoltage and reset coincide
    p_rst_with_uv_r5: assert property (@(posedge clk) disable iff (!por_n)
        uv_flag_i |-> !rst_n_o);
    // R3: warning forced during undervoltage
    p_wd_with_uv_r3: assert property (@(posedge clk) disable iff (!por_n)
        uv_flag_i |-> !wd_n_o);
    // R6: reset outlives the undervoltage flag
    p_rst_after_uv_r6: assert property (@(posedge clk) disable iff (!por_n)
        $fell(uv_flag_i) |-> !rst_n_o);
    // R9: looped-back warning becomes a reset
    p_loop_rst_r9: assert property (@(posedge clk) disable iff (!por_n)
        (loop_en_i && !wd_n_o) |=> !rst_n_o);
endmodule

// File: tb/sim_sup_wdog_top.sv
module sim_sup_wdog_top;
    localparam int CLK_PERIOD = 10;
    localparam int TWP  = 64;
    localparam int TRST = 12;
    localparam int DB   = 6;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic strobe = 1'b0;
    logic uv = 1'b0;
    logic mr_n = 1'b1;
    logic loop_en = 1'b0;
    logic wd_n, rst_n;
    int   checks = 0;
    int   errors = 0;

    sup_wdog_top #(.TWP_CYCLES(TWP), .TRST_CYCLES(TRST), .DB_CYCLES(DB)) u0 (
        .clk(clk), .por_n(por_n), .wd_strobe_i(strobe), .uv_flag_i(uv),
        .mr_n_i(mr_n), .loop_en_i(loop_en), .wd_n_o(wd_n), .rst_n_o(rst_n));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_por();
        @(negedge clk);
        por_n = 1'b0; strobe = 1'b0; uv = 1'b0; mr_n = 1'b1; loop_en = 1'b0;
        step(2);
        por_n = 1'b1;
    endtask

    task automatic t_por();
        do_por();
        #1;
        check("R11", "rst after por", rst_n, 1'b0);
        check("R11", "wd after por", wd_n, 1'b1);
        step(TRST - 1);
        check("R11", "rst before stretch end", rst_n, 1'b0);
        step(1);
        check("R11", "rst at stretch end", rst_n, 1'b1);
    endtask

    task automatic t_timeout();
        do_por();
        step(TRST);
        step(TWP - 1);
        check("R8", "wd one edge before limit", wd_n, 1'b1);
        step(1);
        check("R1", "wd at limit", wd_n, 1'b0);
        step(5);
        check("R9", "no reset with loop off", rst_n, 1'b1);
        check("R7", "warning persists", wd_n, 1'b0);
    endtask

    task automatic t_strobe_edges();
        logic bad;
        bad = 1'b0;
        do_por();
        step(TRST);
        for (int k = 0; k < 5; k++) begin
            for (int j = 0; j < (TWP * 3) / 5; j++) begin
                step(1);
                if (!wd_n) bad = 1'b1;
            end
            strobe = ~strobe;
        end
        check("R2", "both edges keep timer alive", bad, 1'b0);
    endtask

    task automatic t_rearm();
        do_por();
        step(TRST + TWP);
        check("R7", "expired", wd_n, 1'b0);
        step(10);
        check("R7", "still low without edge", wd_n, 1'b0);
        strobe = ~strobe;
        step(2);
        check("R2", "sync latency", wd_n, 1'b0);
        step(1);
        check("R7", "edge releases", wd_n, 1'b1);
        step(TWP - 1);
        check("R7", "restart from zero, before limit", wd_n, 1'b1);
        step(1);
        check("R7", "restart from zero, at limit", wd_n, 1'b0);
    endtask

    task automatic t_uv();
        do_por();
        step(TRST);
        uv = 1'b1;
        #1;
        check("R3", "wd with uv", wd_n, 1'b0);
        check("R5", "rst with uv", rst_n, 1'b0);
        step(3);
        check("R3", "wd held", wd_n, 1'b0);
        uv = 1'b0;
        #1;
        check("R4", "wd releases at once", wd_n, 1'b1);
        check("R6", "rst still low", rst_n, 1'b0);
        step(TRST - 1);
        check("R6", "rst before stretch end", rst_n, 1'b0);
        step(1);
        check("R6", "rst after stretch", rst_n, 1'b1);
        step(TWP);
        check("R1", "expired again", wd_n, 1'b0);
        uv = 1'b1;
        #1;
        check("R3", "wd with uv while expired", wd_n, 1'b0);
        step(2);
        uv = 1'b0;
        #1;
        check("R8", "reset cleared warning", wd_n, 1'b1);
    endtask

    task automatic t_loop();
        do_por();
        loop_en = 1'b1;
        step(TRST + TWP);
        check("R9", "timeout seen", wd_n, 1'b0);
        check("R9", "rst high at timeout", rst_n, 1'b1);
        step(1);
        check("R9", "rst asserted", rst_n, 1'b0);
        step(1);
        check("R9", "warning cleared", wd_n, 1'b1);
        step(TRST - 1);
        check("R6", "loop rst stretched", rst_n, 1'b0);
        step(1);
        check("R6", "loop rst released", rst_n, 1'b1);
    endtask

    task automatic t_mr();
        logic bad;
        bad = 1'b0;
        do_por();
        step(TRST);
        mr_n = 1'b0;
        step(DB - 1);
        mr_n = 1'b1;
        for (int j = 0; j < DB + 6; j++) begin
            step(1);
            if (!rst_n) bad = 1'b1;
        end
        check("R10", "short glitch ignored", bad, 1'b0);
        strobe = ~strobe;
        mr_n = 1'b0;
        step(DB + 2);
        check("R10", "rst before debounce done", rst_n, 1'b1);
        step(1);
        check("R10", "rst after debounce", rst_n, 1'b0);
        step(5);
        mr_n = 1'b1;
        step(DB + 1 + TRST);
        check("R6", "mr rst stretched", rst_n, 1'b0);
        step(1);
        check("R6", "mr rst released", rst_n, 1'b1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_por();
        t_timeout();
        t_strobe_edges();
        t_rearm();
        t_uv();
        t_loop();
        t_mr();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule